// File: doc/BRIEF.md
# Latch-or-Register Bus Path (one direction)

This block carries a data word in one direction of a universal bus transceiver: it is placed once for the forward direction and once more for the reverse direction, and each copy has its own controls. The storage stage has three modes. It can pass the input straight through while the latch enable is high. It can capture the input on a qualified rising edge of the path clock. Otherwise it holds its contents. The output never goes to high impedance. Instead it always carries the path value, and a separate drive-enable flag tells the pad logic when the word may be driven.

The block runs on a fast system clock. The path clock, latch enable, clock enable and output enable are ordinary inputs. The path clock is sampled on every system-clock edge, and a rising edge of the path clock is detected as low on one sample and high on the next. The latch enable and the output enable act on the outputs in the same cycle. Stored data is written only at a system-clock edge. The stored word is built from equal lanes. The default is 18 bits in two 9-bit lanes, and all lanes load together.

Top module: `busPathDir`

## Requirements
- R1: An active-low reset (`rstN` low) clears the stored word to zero at once. After reset, with `latchEn` low and no qualified edge, `dataOut` reads zero.
- R2: `driveEn` is 1 exactly when `outEnN` is 0, in the same cycle, whatever the other inputs are doing.
- R3: While `latchEn` is 1, `dataOut` equals `dataIn` combinationally, whatever `pathClk` and `clkEnN` are doing.
- R4: When `latchEn` is 0 and `clkEnN` is 0, a system-clock edge at which `pathClk` samples 1, after sampling 0 at the previous edge, stores `dataIn`. From that edge on, `dataOut` shows the stored value. This holds for all bits of every lane.
- R5: While `latchEn` is 0 and `clkEnN` is 1, rising edges of `pathClk` leave `dataOut` unchanged.
- R6: While `latchEn` is 0 and `pathClk` stays static (high or low) or falls, `dataOut` keeps its value.
- R7: At every system-clock edge while `latchEn` is 1, the stored word takes `dataIn`. If `latchEn` falls while `pathClk` is high, the last value passed through is held until the next qualified rising edge.
- R8: Changing `outEnN` never alters the stored word. Re-enabling the output presents the last stored data, and a qualified edge still loads while the output is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock that samples all controls |
| rstN | input | 1 | Asynchronous active-low reset |
| pathClk | input | 1 | Path clock; its sampled rising edge triggers a load |
| latchEn | input | 1 | 1 = transparent mode |
| clkEnN | input | 1 | Active-low qualifier for path-clock loads |
| outEnN | input | 1 | Active-low output enable |
| dataIn | input | WIDTH | Input word |
| dataOut | output | WIDTH | Path value (transparent or stored) |
| driveEn | output | 1 | 1 = output word may be driven |

## Verification
Three results have different timing. `driveEn` and the transparent output follow their inputs in the same cycle. A path-clock capture or a stored-word update appears just after the first system-clock edge that sees the new control levels. Each stimulus vector is applied at a falling system-clock edge, and its results are compared 2 ns after the next rising edge, so every registered update has landed and the combinational outputs have settled. The same-cycle cases are also probed 1 ns after an input change, with no clock edge in between, which shows that no register lies on those paths.

// File: rtl/busPathPkg.sv
package busPathPkg;
  // Strobes passed from the mode decoder to the storage datapath.
  typedef struct packed {
    logic passThru;   // output shows the input directly
    logic trackLoad;  // storage follows the input this edge (transparent mode)
    logic edgeLoad;   // qualified path-clock rising edge: capture
    logic drive;      // output drive allowed
  } pathStrobe_t;
endpackage

// File: rtl/busPathCtrl.sv
module busPathCtrl
  import busPathPkg::*;
(
  input  logic        sysClk,
  input  logic        pathClk,
  input  logic        latchEn,
  input  logic        clkEnN,
  input  logic        outEnN,
  output pathStrobe_t strobe
);
  // Previous sample of the path clock. It needs no reset, because it
  // only mirrors an input one cycle late.
  logic prevClk;
  logic clkRise;

  always_ff @(posedge sysClk) begin
    prevClk <= pathClk;
  end

  assign clkRise = pathClk & ~prevClk;

  always_comb begin
    strobe           = '0;
    strobe.passThru  = latchEn;
    strobe.trackLoad = latchEn;
    strobe.edgeLoad  = ~latchEn & ~clkEnN & clkRise;
    strobe.drive     = ~outEnN;
  end
endmodule

// File: rtl/busPathData.sv
module busPathData
  import busPathPkg::*;
#(
  parameter int WIDTH = 18,
  parameter int LANES = 2
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  pathStrobe_t      strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic [WIDTH-1:0] storedOut
);
  localparam int LANE_W = WIDTH / LANES;

  logic [WIDTH-1:0] storedQ;
  logic             laneLoad;

  assign laneLoad = strobe.trackLoad | strobe.edgeLoad;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    localparam int LO = gi * LANE_W;
    localparam int HI = (gi == LANES - 1) ? WIDTH - 1 : LO + LANE_W - 1;
    logic [HI-LO:0] laneQ;

    always_ff @(posedge sysClk or negedge rstN) begin
      if (!rstN) begin
        laneQ <= '0;
      end else if (laneLoad) begin
        laneQ <= dataIn[HI:LO];
      end
    end

    assign storedQ[HI:LO] = laneQ;
  end

  assign dataOut   = strobe.passThru ? dataIn : storedQ;
  assign storedOut = storedQ;

  AST_TRACK_STORES: assert property (@(posedge sysClk) disable iff (!rstN)
    strobe.trackLoad |=> storedQ == $past(dataIn)); // R7
  AST_EDGE_CAPTURE: assert property (@(posedge sysClk) disable iff (!rstN)
    strobe.edgeLoad |=> storedQ == $past(dataIn)); // R4
endmodule

// File: rtl/busPathDir.sv
module busPathDir
  import busPathPkg::*;
#(
  parameter int WIDTH = 18,
  parameter int LANES = 2
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             pathClk,
  input  logic             latchEn,
  input  logic             clkEnN,
  input  logic             outEnN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             driveEn
);
  pathStrobe_t      strobe;
  logic [WIDTH-1:0] storedQ;

  busPathCtrl ctrl_i (
    .sysClk  (sysClk),
    .pathClk (pathClk),
    .latchEn (latchEn),
    .clkEnN  (clkEnN),
    .outEnN  (outEnN),
    .strobe  (strobe)
  );

  busPathData #(.WIDTH(WIDTH), .LANES(LANES)) data_i (
    .sysClk    (sysClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .storedOut (storedQ)
  );

  assign driveEn = strobe.drive;

  AST_CLKEN_HOLD: assert property (@(posedge sysClk) disable iff (!rstN)
    (!latchEn && clkEnN) |=> $stable(storedQ)); // R5
  AST_STATIC_CLK_HOLD: assert property (@(posedge sysClk) disable iff (!rstN)
    (!latchEn && !(pathClk && !$past(pathClk))) |=> $stable(storedQ)); // R6
  AST_OE_NO_TOUCH: assert property (@(posedge sysClk) disable iff (!rstN)
    ($changed(outEnN) && !latchEn && clkEnN) |=> $stable(storedQ)); // R8
endmodule

// File: tb/busPathDir_tb.sv
module busPathDir_tb_top;
  localparam int W = 18;

  typedef struct packed {
    logic         le;
    logic         cenN;
    logic         oeN;
    logic         pclk;
    logic [W-1:0] din;
    logic [W-1:0] dout;
    logic         drv;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 18'h01234, 18'h01234, 1'b1, 4'd3}, // R3
    '{1'b1, 1'b0, 1'b0, 1'b1, 18'h2ABCD, 18'h2ABCD, 1'b1, 4'd3}, // R3 edge ignored
    '{1'b1, 1'b1, 1'b0, 1'b0, 18'h0F0F0, 18'h0F0F0, 1'b1, 4'd3}, // R3
    '{1'b0, 1'b1, 1'b0, 1'b0, 18'h33333, 18'h0F0F0, 1'b1, 4'd6}, // R6 closed, clock low
    '{1'b0, 1'b1, 1'b0, 1'b1, 18'h11111, 18'h0F0F0, 1'b1, 4'd5}, // R5 edge, disabled
    '{1'b0, 1'b1, 1'b0, 1'b0, 18'h11111, 18'h0F0F0, 1'b1, 4'd5}, // R5
    '{1'b0, 1'b0, 1'b0, 1'b1, 18'h15A5A, 18'h15A5A, 1'b1, 4'd4}, // R4 capture
    '{1'b0, 1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h15A5A, 1'b1, 4'd6}, // R6 static high
    '{1'b0, 1'b0, 1'b0, 1'b0, 18'h00001, 18'h15A5A, 1'b1, 4'd6}, // R6 falling
    '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00002, 18'h15A5A, 1'b0, 4'd8}, // R8 output off
    '{1'b0, 1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h3FFFF, 1'b0, 4'd4}, // R4 all lanes, output off
    '{1'b0, 1'b0, 1'b0, 1'b1, 18'h00005, 18'h3FFFF, 1'b1, 4'd8}, // R8 re-enable
    '{1'b1, 1'b0, 1'b0, 1'b1, 18'h2468A, 18'h2468A, 1'b1, 4'd3}, // R3
    '{1'b0, 1'b0, 1'b0, 1'b1, 18'h2468A, 18'h2468A, 1'b1, 4'd7}, // R7 close, clock high
    '{1'b0, 1'b0, 1'b0, 1'b1, 18'h13579, 18'h2468A, 1'b1, 4'd7}, // R7 held
    '{1'b0, 1'b0, 1'b0, 1'b0, 18'h13579, 18'h2468A, 1'b1, 4'd7}, // R7 held
    '{1'b0, 1'b0, 1'b0, 1'b1, 18'h13579, 18'h13579, 1'b1, 4'd7}  // R7 next edge
  };

  logic         sysClk = 1'b0;
  logic         rstN;
  logic         pathClk;
  logic         latchEn;
  logic         clkEnN;
  logic         outEnN;
  logic [W-1:0] dataIn;
  logic [W-1:0] dataOut;
  logic         driveEn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 sysClk = ~sysClk;

  busPathDir #(.WIDTH(W), .LANES(2)) dut_i (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .pathClk (pathClk),
    .latchEn (latchEn),
    .clkEnN  (clkEnN),
    .outEnN  (outEnN),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .driveEn (driveEn)
  );

  task automatic check(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rstN = 1'b0; pathClk = 1'b0; latchEn = 1'b0; clkEnN = 1'b1;
    outEnN = 1'b1; dataIn = '0;
    repeat (3) @(negedge sysClk);
    check("R1 reset dataOut", dataOut, '0);
    check("R2 reset driveEn", {17'b0, driveEn}, '0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge sysClk);
      latchEn = VECS[i].le;   clkEnN = VECS[i].cenN;
      outEnN  = VECS[i].oeN;  pathClk = VECS[i].pclk;
      dataIn  = VECS[i].din;
      @(posedge sysClk);
      #2;
      check($sformatf("R%0d vec %0d dataOut", VECS[i].req, i), dataOut, VECS[i].dout);
      check($sformatf("R2 vec %0d driveEn", i), {17'b0, driveEn}, {17'b0, VECS[i].drv});
    end

    // R3 same-cycle pass-through, no clock edge in between
    @(negedge sysClk);
    latchEn = 1'b1; dataIn = 18'h0AAAA;
    #1 check("R3 comb pass A", dataOut, 18'h0AAAA);
    dataIn = 18'h05555;
    #1 check("R3 comb pass B", dataOut, 18'h05555);
    // R2 same-cycle drive flag
    outEnN = 1'b1;
    #1 check("R2 comb off", {17'b0, driveEn}, '0);
    outEnN = 1'b0;
    #1 check("R2 comb on", {17'b0, driveEn}, 18'h1);
    @(posedge sysClk);

    // R1 mid-run reset clears storage immediately
    @(negedge sysClk);
    latchEn = 1'b0;
    #1 check("R7 stored tracked value", dataOut, 18'h05555);
    rstN = 1'b0;
    #1 check("R1 async clear", dataOut, '0);
    @(negedge sysClk);
    rstN = 1'b1;
    @(posedge sysClk);
    #2 check("R1 stays clear", dataOut, '0);

    // R4 capture after reset
    @(negedge sysClk);
    pathClk = 1'b0;
    @(negedge sysClk);
    pathClk = 1'b1; dataIn = 18'h3C3C3;
    @(posedge sysClk);
    #2 check("R4 capture after reset", dataOut, 18'h3C3C3);

    finish_run();
  end
endmodule